// File: doc/BRIEF.md
# Return Link Stack with Overflow and Underflow Trap Requests

This block holds the return linkage of an instruction fetch unit. Each entry pairs a return program counter with the caller's saved local-frame base. A call strobe pushes one entry. A return strobe pops the newest entry, and the block presents that entry's two fields to the fetch logic on the following cycle. Spilling entries to memory and filling them back belong to a neighbouring unit, which reads the occupancy count and the empty and at-limit flags.

The stack has a soft limit that sits below its physical depth. A call that arrives while the occupancy is at or above the soft limit is still accepted. If overflow trapping is enabled, the block also raises an overflow trap request one cycle later. The entries between the soft limit and the physical depth are a reserve, so the trap handler can still make calls. A return that finds the stack empty does not cancel. It raises an underflow trap request together with a request to disable maskable traps, and the stack stays empty. A call that finds every physical entry occupied is dropped and sets a sticky error flag.

The control path is a small state machine whose state records what happened on the previous cycle. There are four states:
- `ST_IDLE`: no pulse is driven.
- `ST_POPPED`: the return fields are valid.
- `ST_OVF`: the overflow request pulse is driven.
- `ST_UNF`: the underflow request and the mask-off pulse are driven.

The transitions are:
- `T_RET_OK`: a return on a non-empty stack moves to `ST_POPPED`.
- `T_RET_EMPTY`: a return on an empty stack moves to `ST_UNF`.
- `T_CALL_LIMIT`: an enabled call at or above the soft limit moves to `ST_OVF`.
- `T_QUIET`: every other cycle, including a clash of call and return, moves to `ST_IDLE`.

Every state leaves after one cycle.

Top module: `link_stack`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, at_limit_o is 0, err_o is 0, and ret_valid_o, ovf_trap_o, unf_trap_o and mask_off_o are all 0.
- R2: A call alone on a stack that is not full stores {call_pc_i, call_lb_i} and raises count_o by one on the next cycle.
- R3: A return alone on a non-empty stack lowers count_o by one. On the next cycle it drives ret_valid_o high for one cycle, with ret_pc_o and ret_lb_o equal to the newest stored entry (last in, first out).
- R4: empty_o is 1 exactly when count_o is 0, and at_limit_o is 1 exactly when count_o is at least DEPTH-RESERVE (12 with the defaults DEPTH=16 and RESERVE=4).
- R5: A call alone with ovf_en_i=1 while count_o is at least DEPTH-RESERVE raises ovf_trap_o for exactly one cycle, on the cycle after the call. When the stack is not full, the entry is still pushed.
- R6: With ovf_en_i=0, a call at or above the soft limit raises no ovf_trap_o and is still pushed.
- R7: Calls above the soft limit are accepted until count_o reaches DEPTH, and the reserve entries return their data in order.
- R8: A call while count_o equals DEPTH is dropped. count_o and the stored entries are unchanged, and err_o becomes 1 and stays 1 until reset.
- R9: A return alone on an empty stack raises unf_trap_o and mask_off_o together for one cycle on the next cycle. It does not raise ret_valid_o, and count_o stays 0.
- R10: A call and a return in the same cycle are both rejected. count_o and the stored entries are unchanged, and no pulse output rises.
- R11: Reset clears the sticky error flag and empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe (push) |
| ret_i | input | 1 | Return strobe (pop) |
| call_pc_i | input | PC_W | Return program counter to store |
| call_lb_i | input | LB_W | Local-frame base to store |
| ovf_en_i | input | 1 | Overflow trapping enable |
| ret_pc_o | output | PC_W | Popped return program counter |
| ret_lb_o | output | LB_W | Popped local-frame base |
| ret_valid_o | output | 1 | Popped fields valid (one cycle) |
| ovf_trap_o | output | 1 | Overflow trap request pulse |
| unf_trap_o | output | 1 | Underflow trap request pulse |
| mask_off_o | output | 1 | Request to disable maskable traps |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| empty_o | output | 1 | Stack empty |
| at_limit_o | output | 1 | Occupancy at or above soft limit |
| err_o | output | 1 | Sticky dropped-call error |

## Verification
The properties assume that call_i and ret_i are plain one-cycle strobes, sampled at the clock edge and stable over the cycle. They also assume that ovf_en_i is settled whenever a call is presented. The stimulus changes every input only on the falling clock edge and leaves an idle cycle after each operation. It asserts both strobes together only in the clash case, where the block is required to reject the pair. The scoreboard predicts each popped entry from its own model of the stack, so the stimulus can fill past the soft limit and past the physical depth without relying on anything inside the design.

// File: rtl/link_stack_pkg.sv
package link_stack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POPPED,
        ST_OVF,
        ST_UNF
    } ls_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_PUSH,
        CMD_POP,
        CMD_CLASH
    } ls_cmd_e;

endpackage

// File: rtl/link_stack_occ.sv
module link_stack_occ #(
    parameter int DEPTH   = 16,
    parameter int RESERVE = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic             drop,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             at_limit,
    output logic             err
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(DEPTH - RESERVE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            if (push_en) begin
                count <= count + 1'b1;
            end else if (pop_en) begin
                count <= count - 1'b1;
            end
            if (drop) begin
                err <= 1'b1;
            end
        end
    end

    always_comb begin
        empty    = (count == '0);
        full     = (count == DEPTH_C);
        at_limit = (count >= LIMIT_C);
    end

endmodule

// File: rtl/link_stack_mem.sv
module link_stack_mem #(
    parameter int DEPTH  = 16,
    parameter int PC_W   = 32,
    parameter int LB_W   = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = PC_W + LB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic [CNT_W-1:0] count,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [LB_W-1:0]  wr_lb,
    output logic [PC_W-1:0]  rd_pc,
    output logic [LB_W-1:0]  rd_lb
);
    logic [ENT_W-1:0] slot [DEPTH];
    logic [ENT_W-1:0] top_ent;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ENT_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (push_en && (count == CNT_W'(g))) begin
                ent_q <= {wr_pc, wr_lb};
            end
        end
        assign slot[g] = ent_q;
    end

    always_comb begin
        top_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count == CNT_W'(i + 1)) begin
                top_ent = slot[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pc <= '0;
            rd_lb <= '0;
        end else if (pop_en) begin
            rd_pc <= top_ent[ENT_W-1:LB_W];
            rd_lb <= top_ent[LB_W-1:0];
        end
    end

endmodule

// File: rtl/link_stack_ctrl.sv
module link_stack_ctrl
    import link_stack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic call_i,
    input  logic ret_i,
    input  logic ovf_en_i,
    input  logic empty,
    input  logic full,
    input  logic at_limit,
    output logic push_en,
    output logic pop_en,
    output logic drop,
    output logic ret_valid,
    output logic ovf_trap,
    output logic unf_trap,
    output logic mask_off
);
    ls_state_e state_q;
    ls_state_e state_d;
    ls_cmd_e   cmd;

    always_comb begin
        if (call_i && ret_i) begin
            cmd = CMD_CLASH;
        end else if (call_i) begin
            cmd = CMD_PUSH;
        end else if (ret_i) begin
            cmd = CMD_POP;
        end else begin
            cmd = CMD_NONE;
        end
    end

    always_comb begin
        push_en = (cmd == CMD_PUSH) && !full;
        drop    = (cmd == CMD_PUSH) && full;
        pop_en  = (cmd == CMD_POP) && !empty;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (cmd)
            CMD_POP:   state_d = empty ? ST_UNF : ST_POPPED;
            CMD_PUSH:  state_d = (at_limit && ovf_en_i) ? ST_OVF : ST_IDLE;
            CMD_NONE:  state_d = ST_IDLE;
            CMD_CLASH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ret_valid = 1'b0;
        ovf_trap  = 1'b0;
        unf_trap  = 1'b0;
        mask_off  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_POPPED: ret_valid = 1'b1;
            ST_OVF:    ovf_trap  = 1'b1;
            ST_UNF: begin
                unf_trap = 1'b1;
                mask_off = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/link_stack.sv
module link_stack #(
    parameter int DEPTH   = 16,
    parameter int RESERVE = 4,
    parameter int PC_W    = 32,
    parameter int LB_W    = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic [PC_W-1:0]  call_pc_i,
    input  logic [LB_W-1:0]  call_lb_i,
    input  logic             ovf_en_i,
    output logic [PC_W-1:0]  ret_pc_o,
    output logic [LB_W-1:0]  ret_lb_o,
    output logic             ret_valid_o,
    output logic             ovf_trap_o,
    output logic             unf_trap_o,
    output logic             mask_off_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o,
    output logic             at_limit_o,
    output logic             err_o
);
    logic push_en;
    logic pop_en;
    logic drop;
    logic full;

    link_stack_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .ovf_en_i  (ovf_en_i),
        .empty     (empty_o),
        .full      (full),
        .at_limit  (at_limit_o),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .drop      (drop),
        .ret_valid (ret_valid_o),
        .ovf_trap  (ovf_trap_o),
        .unf_trap  (unf_trap_o),
        .mask_off  (mask_off_o)
    );

    link_stack_occ #(
        .DEPTH   (DEPTH),
        .RESERVE (RESERVE)
    ) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .drop     (drop),
        .count    (count_o),
        .empty    (empty_o),
        .full     (full),
        .at_limit (at_limit_o),
        .err      (err_o)
    );

    link_stack_mem #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .LB_W  (LB_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (push_en),
        .pop_en  (pop_en),
        .count   (count_o),
        .wr_pc   (call_pc_i),
        .wr_lb   (call_lb_i),
        .rd_pc   (ret_pc_o),
        .rd_lb   (ret_lb_o)
    );

endmodule

// File: rtl/link_stack_chk.sv
module link_stack_chk #(
    parameter int DEPTH   = 16,
    parameter int RESERVE = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_i,
    input logic             ret_i,
    input logic             ovf_en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             empty_o,
    input logic             at_limit_o,
    input logic             ret_valid_o,
    input logic             ovf_trap_o,
    input logic             unf_trap_o,
    input logic             mask_off_o,
    input logic             err_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(DEPTH - RESERVE);

    a_r2_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && count_o < DEPTH_C) |=> (count_o == $past(count_o) + 1'b1));

    a_r3_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !empty_o) |=> (ret_valid_o && count_o == $past(count_o) - 1'b1));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= DEPTH_C);

    a_r5_ovf_req: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && ovf_en_i && count_o >= LIMIT_C) |=> ovf_trap_o);

    a_r6_no_ovf_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ovf_en_i) |=> !ovf_trap_o);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && empty_o) |=> (unf_trap_o && mask_off_o && count_o == '0));

    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_valid_o, ovf_trap_o, unf_trap_o}));

    a_r10_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> ($stable(count_o) && !ret_valid_o && !ovf_trap_o && !unf_trap_o));

endmodule

bind link_stack link_stack_chk #(
    .DEPTH   (DEPTH),
    .RESERVE (RESERVE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .ovf_en_i    (ovf_en_i),
    .count_o     (count_o),
    .empty_o     (empty_o),
    .at_limit_o  (at_limit_o),
    .ret_valid_o (ret_valid_o),
    .ovf_trap_o  (ovf_trap_o),
    .unf_trap_o  (unf_trap_o),
    .mask_off_o  (mask_off_o),
    .err_o       (err_o)
);

// File: tb/link_stack_bench.sv
module link_stack_bench;
    localparam int DEPTH   = 16;
    localparam int RESERVE = 4;
    localparam int LIMIT   = DEPTH - RESERVE;
    localparam int PC_W    = 32;
    localparam int LB_W    = 8;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             call_i = 1'b0;
    logic             ret_i = 1'b0;
    logic [PC_W-1:0]  call_pc_i = '0;
    logic [LB_W-1:0]  call_lb_i = '0;
    logic             ovf_en_i = 1'b0;
    logic [PC_W-1:0]  ret_pc_o;
    logic [LB_W-1:0]  ret_lb_o;
    logic             ret_valid_o;
    logic             ovf_trap_o;
    logic             unf_trap_o;
    logic             mask_off_o;
    logic [CNT_W-1:0] count_o;
    logic             empty_o;
    logic             at_limit_o;
    logic             err_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [PC_W-1:0]      m_pc [DEPTH];
    logic [LB_W-1:0]      m_lb [DEPTH];
    int                   m_cnt = 0;
    logic                 m_err = 1'b0;
    logic [PC_W+LB_W-1:0] exp_q [$];

    always #10 clk = ~clk;

    link_stack #(
        .DEPTH   (DEPTH),
        .RESERVE (RESERVE),
        .PC_W    (PC_W),
        .LB_W    (LB_W)
    ) u_link_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .call_pc_i   (call_pc_i),
        .call_lb_i   (call_lb_i),
        .ovf_en_i    (ovf_en_i),
        .ret_pc_o    (ret_pc_o),
        .ret_lb_o    (ret_lb_o),
        .ret_valid_o (ret_valid_o),
        .ovf_trap_o  (ovf_trap_o),
        .unf_trap_o  (unf_trap_o),
        .mask_off_o  (mask_off_o),
        .count_o     (count_o),
        .empty_o     (empty_o),
        .at_limit_o  (at_limit_o),
        .err_o       (err_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares every popped entry against the scoreboard queue (R3, R7).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ret_valid_o) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected ret_valid_o", 64'd1, 64'd0);
                end else begin
                    check("R3 popped entry", {24'd0, ret_pc_o, ret_lb_o}, {24'd0, exp_q.pop_front()});
                end
            end
        end
    end

    task automatic step(input logic c, input logic r, input logic en,
                        input logic [PC_W-1:0] pc, input logic [LB_W-1:0] lb);
        logic e_ovf;
        logic e_unf;
        logic e_pop;
        e_ovf = c && !r && en && (m_cnt >= LIMIT);
        e_unf = r && !c && (m_cnt == 0);
        e_pop = r && !c && (m_cnt > 0);
        if (c && !r) begin
            if (m_cnt < DEPTH) begin
                m_pc[m_cnt] = pc;
                m_lb[m_cnt] = lb;
                m_cnt++;
            end else begin
                m_err = 1'b1;
            end
        end
        if (e_pop) begin
            m_cnt--;
            exp_q.push_back({m_pc[m_cnt], m_lb[m_cnt]});
        end
        @(negedge clk);
        call_i    = c;
        ret_i     = r;
        ovf_en_i  = en;
        call_pc_i = pc;
        call_lb_i = lb;
        @(negedge clk);
        call_i = 1'b0;
        ret_i  = 1'b0;
        check("R2 count_o", 64'(count_o), 64'(m_cnt));
        check("R4 empty_o", 64'(empty_o), 64'(m_cnt == 0));
        check("R4 at_limit_o", 64'(at_limit_o), 64'(m_cnt >= LIMIT));
        check("R5 ovf_trap_o", 64'(ovf_trap_o), 64'(e_ovf));
        check("R9 unf_trap_o", 64'(unf_trap_o), 64'(e_unf));
        check("R9 mask_off_o", 64'(mask_off_o), 64'(e_unf));
        check("R3 ret_valid_o", 64'(ret_valid_o), 64'(e_pop));
        check("R8 err_o", 64'(err_o), 64'(m_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
        m_err = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                check("watchdog expired", 64'd1, 64'd0);
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1: reset state
                check("R1 count_o", 64'(count_o), 64'd0);
                check("R1 empty_o", 64'(empty_o), 64'd1);
                check("R1 at_limit_o", 64'(at_limit_o), 64'd0);
                check("R1 pulses", 64'({ret_valid_o, ovf_trap_o, unf_trap_o, mask_off_o}), 64'd0);
                check("R1 err_o", 64'(err_o), 64'd0);

                // R2, R3: small LIFO run
                step(1, 0, 1, 32'h0000_1000, 8'h11);
                step(1, 0, 1, 32'h0000_2004, 8'h22);
                step(1, 0, 1, 32'h0000_3008, 8'h33);
                step(0, 1, 1, '0, '0);
                step(1, 0, 1, 32'h0000_400C, 8'h44);
                step(0, 1, 1, '0, '0);
                step(0, 1, 1, '0, '0);
                step(0, 1, 1, '0, '0);

                // R9: return on empty stack
                step(0, 1, 1, '0, '0);
                step(0, 1, 0, '0, '0);

                // R10: clash of call and return
                step(1, 0, 1, 32'hA000_0000, 8'h5A);
                step(1, 1, 1, 32'hDEAD_BEEF, 8'hEE);
                step(0, 1, 1, '0, '0);
                step(1, 1, 1, 32'hDEAD_BEEF, 8'hEE);
                check("R10 still empty", 64'(count_o), 64'd0);

                // R4, R6: fill to soft limit, then call with trapping disabled
                for (int i = 0; i < LIMIT; i++) begin
                    step(1, 0, 1, 32'(32'hC000_0000 + i * 4), 8'(i));
                end
                step(1, 0, 0, 32'hC100_0000, 8'hA0);
                // R5: enabled call above soft limit
                step(1, 0, 1, 32'hC200_0000, 8'hA1);
                // R7: use the reserve up to physical depth
                while (m_cnt < DEPTH) begin
                    step(1, 0, 1, 32'(32'hC300_0000 + m_cnt), 8'(8'hB0 + m_cnt));
                end
                // R8: calls beyond physical depth are dropped, error sticks
                step(1, 0, 1, 32'hBAD0_0000, 8'hFF);
                step(1, 0, 0, 32'hBAD0_0001, 8'hFE);
                step(0, 0, 0, '0, '0);
                // R7, R8: drain, newest accepted entries come out first
                for (int i = 0; i < DEPTH; i++) begin
                    step(0, 1, 1, '0, '0);
                end
                step(0, 1, 1, '0, '0);
                check("R8 err_o holds", 64'(err_o), 64'd1);

                // R11: reset clears error and stack
                step(1, 0, 1, 32'h0000_7777, 8'h77);
                do_reset();
                @(negedge clk);
                check("R11 err_o cleared", 64'(err_o), 64'd0);
                check("R11 count_o cleared", 64'(count_o), 64'd0);
                step(0, 1, 1, '0, '0);
                check("R11 scoreboard drained", 64'(exp_q.size()), 64'd0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule